// File: doc/BRIEF.md
# Configuration Integrity Guard

This block watches over the safety-relevant configuration of a sensor front end. Three independent checks run side by side. A rolling CRC walks the bank of critical configuration bytes, one byte per clock, and compares the finished signature with a stored reference at the end of every pass. A mirror comparator checks each critical byte against its shadow copy on every cycle. A strap monitor records the mode-strap pin levels when initialization completes and then looks for any later change.

A failed check raises a sticky request to enter the shut-down (disabled) state. A cause code names the check that failed first. The two test straps fault on any change. The gain-mode strap faults only when its change persists for a programmable number of cycles. The surrounding state machine uses the request to take the device down and to start a recovery. Only a reset clears the request.

Top module: `cfg_integrity_guard`

## Requirements
- R1: The signature is CRC-8, polynomial 0x07, seed 0xFF, MSB first, with no reflection and no final XOR. It is taken over bytes 0 to NUM_REGS-1 in that order, where byte i is `cfg_bank[8i+7:8i]`. A pass that ends with a result different from `crc_expected` raises the request with cause 2 within 2*NUM_REGS+4 cycles of the change.
- R2: Any difference between `cfg_bank` and `shadow_bank` raises the request with cause 1 on the second rising clock edge after the difference appears, with no filtering.
- R3: After capture, a change of either bit of `strap_test` raises the request with cause 3 within four clock edges.
- R4: A mismatch on `strap_gain` raises the request with cause 4 only after it has lasted DEGLITCH_CYCLES consecutive cycles after synchronization. A shorter excursion that returns to the captured level leaves the outputs unchanged.
- R5: The strap levels are captured on the first cycle with `init_done` high. Strap changes before that cycle raise no fault.
- R6: When several checks fail in the same cycle, the recorded cause follows the priority mirror (1) > CRC (2) > test strap (3) > gain strap (4).
- R7: After the first fault, `disable_req` and `fault_cause` stay unchanged until reset, whatever other checks report.
- R8: `rst_n` low clears both outputs at once: `disable_req` = 0 and `fault_cause` = 0, where 0 means no fault.
- R9: `disable_req` is high exactly when `fault_cause` is non-zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_bank | input | 8*NUM_REGS | Critical configuration bytes, byte i at bits 8i+7:8i |
| shadow_bank | input | 8*NUM_REGS | Redundant copy of the configuration bytes |
| crc_expected | input | 8 | Stored reference signature |
| strap_test | input | NUM_TEST_STRAPS | Test/mode strap pins, no filtering |
| strap_gain | input | 1 | Gain-mode strap pin, filtered |
| init_done | input | 1 | Initialization-complete strobe |
| disable_req | output | 1 | Sticky request to enter the disabled state |
| fault_cause | output | 3 | First fault: 0 none, 1 mirror, 2 CRC, 3 test strap, 4 gain strap |

## Verification
The hardest case to reach is a CRC-only failure. A changed byte also trips the mirror check unless the shadow changes with it, and the mirror check has higher priority. The bench therefore writes the same new byte into both banks while it keeps the old reference signature. Its table entries also pair a flipped shadow with a flipped reference, to confirm that priority decides between the two. The gain-strap filter is tested from both sides: a six-cycle excursion must leave no trace, and a held change must latch cause 4.

// File: rtl/cig_pkg.sv
package cig_pkg;

  typedef enum logic [2:0] {
    CAUSE_NONE   = 3'd0,
    CAUSE_MIRROR = 3'd1,
    CAUSE_CRC    = 3'd2,
    CAUSE_STRAP  = 3'd3,
    CAUSE_GAIN   = 3'd4
  } cause_e;

  localparam logic [7:0] CRC_POLY = 8'h07;
  localparam logic [7:0] CRC_SEED = 8'hFF;

  // Fold one byte into a running CRC-8, most significant bit first.
  function automatic logic [7:0] crc8_fold(input logic [7:0] acc, input logic [7:0] data);
    logic [7:0] c;
    c = acc ^ data;
    for (int b = 0; b < 8; b++) begin
      c = c[7] ? ((c << 1) ^ CRC_POLY) : (c << 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/cig_crc_scan.sv
module cig_crc_scan #(
  parameter int NUM_REGS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [8*NUM_REGS-1:0] cfg_bank,
  input  logic [7:0]            crc_expected,
  output logic                  crc_err
);
  import cig_pkg::*;

  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic [7:0]       acc_q, acc_d;
  logic             err_q, err_d;
  logic [7:0]       cur_byte, seed, folded;
  logic             at_last;

  always_comb begin
    cur_byte = cfg_bank[int'(idx_q)*8 +: 8];
    seed     = (idx_q == '0) ? CRC_SEED : acc_q;
    folded   = crc8_fold(seed, cur_byte);
    at_last  = (idx_q == LAST_IDX);
    idx_d    = at_last ? '0 : idx_q + 1'b1;
    acc_d    = folded;
    err_d    = at_last ? (folded != crc_expected) : err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      acc_q <= '0;
      err_q <= 1'b0;
    end else begin
      idx_q <= idx_d;
      acc_q <= acc_d;
      err_q <= err_d;
    end
  end

  assign crc_err = err_q;

  // R1: byte pointer never leaves the bank
  a_r1_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= LAST_IDX);

  // R1: the verdict only changes when a pass wraps
  a_r1_verdict_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q != '0) |-> $stable(err_q));

endmodule

// File: rtl/cig_mirror_cmp.sv
module cig_mirror_cmp #(
  parameter int NUM_REGS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [8*NUM_REGS-1:0] cfg_bank,
  input  logic [8*NUM_REGS-1:0] shadow_bank,
  output logic                  mirror_err
);
  logic [NUM_REGS-1:0] byte_diff;
  logic                err_q, err_d;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_cmp
    assign byte_diff[i] = (cfg_bank[8*i +: 8] != shadow_bank[8*i +: 8]);
  end

  always_comb err_d = |byte_diff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign mirror_err = err_q;

  // R2: a mismatch is flagged on the very next edge
  a_r2_mirror_next_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_bank != shadow_bank) |=> mirror_err);

endmodule

// File: rtl/cig_strap_watch.sv
module cig_strap_watch #(
  parameter int NUM_TEST_STRAPS = 2,
  parameter int DEGLITCH_CYCLES = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_TEST_STRAPS-1:0] strap_test,
  input  logic                       strap_gain,
  input  logic                       init_done,
  output logic                       test_err,
  output logic                       gain_err
);
  localparam int PINS  = NUM_TEST_STRAPS + 1;
  localparam int GAIN  = NUM_TEST_STRAPS;
  localparam int CNT_W = $clog2(DEGLITCH_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEGLITCH_CYCLES);

  logic [PINS-1:0]  sync1_q, sync2_q, cap_q, cap_d, mism;
  logic             armed_q, armed_d, capture_en;
  logic             test_err_q, test_err_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // two-flop synchronizer per pin
  for (genvar p = 0; p < PINS; p++) begin : g_sync
    logic pin_raw;
    if (p == GAIN) begin : g_gain
      assign pin_raw = strap_gain;
    end else begin : g_test
      assign pin_raw = strap_test[p];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync1_q[p] <= 1'b0;
        sync2_q[p] <= 1'b0;
      end else begin
        sync1_q[p] <= pin_raw;
        sync2_q[p] <= sync1_q[p];
      end
    end
  end

  always_comb begin
    capture_en = init_done && !armed_q;
    armed_d    = armed_q || init_done;
    cap_d      = capture_en ? sync2_q : cap_q;
    mism       = sync2_q ^ cap_q;
    test_err_d = armed_q && (|mism[NUM_TEST_STRAPS-1:0]);
    if (!(armed_q && mism[GAIN]))  cnt_d = '0;
    else if (cnt_q == CNT_MAX)     cnt_d = cnt_q;
    else                           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q    <= 1'b0;
      cap_q      <= '0;
      test_err_q <= 1'b0;
      cnt_q      <= '0;
    end else begin
      armed_q    <= armed_d;
      if (capture_en) cap_q <= cap_d;
      test_err_q <= test_err_d;
      cnt_q      <= cnt_d;
    end
  end

  assign test_err = test_err_q;
  assign gain_err = (cnt_q == CNT_MAX);

  // R4: the filter counter saturates at the de-glitch length
  a_r4_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);

  // R4: a gain fault implies the mismatch was present on the previous cycle
  a_r4_gain_persisted: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gain_err) |-> $past(armed_q && mism[GAIN]));

  // R5: capture happens once; the stored levels never move afterwards
  a_r5_capture_once: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> $stable(cap_q));

endmodule

// File: rtl/cfg_integrity_guard.sv
module cfg_integrity_guard #(
  parameter int NUM_REGS        = 8,
  parameter int NUM_TEST_STRAPS = 2,
  parameter int DEGLITCH_CYCLES = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [8*NUM_REGS-1:0]      cfg_bank,
  input  logic [8*NUM_REGS-1:0]      shadow_bank,
  input  logic [7:0]                 crc_expected,
  input  logic [NUM_TEST_STRAPS-1:0] strap_test,
  input  logic                       strap_gain,
  input  logic                       init_done,
  output logic                       disable_req,
  output logic [2:0]                 fault_cause
);
  import cig_pkg::*;

  logic   rst_meta_q, rst_sync_q;
  logic   crc_err, mirror_err, test_err, gain_err;
  cause_e cause_q, cause_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  cig_crc_scan #(.NUM_REGS(NUM_REGS)) u_crc (
    .clk          (clk),
    .rst_n        (rst_sync_q),
    .cfg_bank     (cfg_bank),
    .crc_expected (crc_expected),
    .crc_err      (crc_err)
  );

  cig_mirror_cmp #(.NUM_REGS(NUM_REGS)) u_mirror (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .cfg_bank    (cfg_bank),
    .shadow_bank (shadow_bank),
    .mirror_err  (mirror_err)
  );

  cig_strap_watch #(
    .NUM_TEST_STRAPS (NUM_TEST_STRAPS),
    .DEGLITCH_CYCLES (DEGLITCH_CYCLES)
  ) u_strap (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .strap_test (strap_test),
    .strap_gain (strap_gain),
    .init_done  (init_done),
    .test_err   (test_err),
    .gain_err   (gain_err)
  );

  always_comb begin
    cause_d = cause_q;
    if (cause_q == CAUSE_NONE) begin
      if      (mirror_err) cause_d = CAUSE_MIRROR;
      else if (crc_err)    cause_d = CAUSE_CRC;
      else if (test_err)   cause_d = CAUSE_STRAP;
      else if (gain_err)   cause_d = CAUSE_GAIN;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) cause_q <= CAUSE_NONE;
    else if (cause_q == CAUSE_NONE) cause_q <= cause_d;
  end

  assign fault_cause = cause_q;
  assign disable_req = (cause_q != CAUSE_NONE);

  // R7: once raised, the request and its cause are frozen
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_sync_q)
    disable_req |=> (disable_req && $stable(fault_cause)));

  // R2: mirror mismatch reaches the request two edges later
  a_r2_mirror_to_req: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (cfg_bank != shadow_bank) |=> ##1 disable_req);

  // R6: a new request carries the highest-priority pending cause
  a_r6_priority: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $rose(disable_req) |-> (($past(mirror_err) && fault_cause == 3'd1) ||
                            (!$past(mirror_err) && $past(crc_err) && fault_cause == 3'd2) ||
                            (!$past(mirror_err) && !$past(crc_err) && $past(test_err) && fault_cause == 3'd3) ||
                            (!$past(mirror_err) && !$past(crc_err) && !$past(test_err) && fault_cause == 3'd4)));

  // R8: only defined cause codes appear
  a_r8_code_legal: assert property (@(posedge clk) disable iff (!rst_sync_q)
    fault_cause <= 3'd4);

endmodule

// File: tb/tb_cfg_integrity_guard.sv
module tb_cfg_integrity_guard;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 8;
  localparam int NTS  = 2;
  localparam int DG   = 16;
  localparam int VW   = 64 + 64 + 8 + 3;
  localparam int NVEC = 6;

  // {bank, shadow flip mask, reference flip mask, expected cause}
  localparam logic [VW-1:0] VECS [NVEC] = '{
    {64'h0706050403020100, 64'h0,                8'h00, 3'd0},
    {64'hDEADBEEFCAFEF00D, 64'h0,                8'h00, 3'd0},
    {64'hDEADBEEFCAFEF00D, 64'h0,                8'h01, 3'd2},
    {64'h0000000000000000, 64'h0000010000000000, 8'h00, 3'd1},
    {64'hFFFFFFFFFFFFFFFF, 64'h8000000000000000, 8'h80, 3'd1},
    {64'h123456789ABCDEF0, 64'h0,                8'hFF, 3'd2}
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic [8*NREG-1:0] cfg_bank, shadow_bank;
  logic [7:0]        crc_expected;
  logic [NTS-1:0]    strap_test;
  logic              strap_gain, init_done;
  logic              disable_req;
  logic [2:0]        fault_cause;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_integrity_guard #(.NUM_REGS(NREG), .NUM_TEST_STRAPS(NTS), .DEGLITCH_CYCLES(DG)) dut (
    .clk, .rst_n, .cfg_bank, .shadow_bank, .crc_expected,
    .strap_test, .strap_gain, .init_done, .disable_req, .fault_cause
  );

  function automatic logic [7:0] ref_crc(input logic [8*NREG-1:0] bank);
    logic [7:0] c = 8'hFF;
    for (int i = 0; i < NREG; i++) begin
      c ^= bank[8*i +: 8];
      for (int b = 0; b < 8; b++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    end
    return c;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic restart(input logic [8*NREG-1:0] bank, input logic [8*NREG-1:0] sflip,
                         input logic [7:0] cflip);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_bank = bank;
    shadow_bank = bank ^ sflip;
    crc_expected = ref_crc(bank) ^ cflip;
    strap_test = 2'b01;
    strap_gain = 1'b1;
    init_done = 1'b0;
    cyc(3);
    rst_n = 1'b1;
  endtask

  task automatic arm();
    cyc(4);
    init_done = 1'b1;
    cyc(1);
    init_done = 1'b0;
    cyc(2);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    restart(64'h0706050403020100, 64'h0, 8'h00);
    rst_n = 1'b0;
    cyc(1);
    chk("R8 reset disable_req", int'(disable_req), 0);
    chk("R8 reset cause", int'(fault_cause), 0);

    // table of bank patterns and corruptions (R1, R2, R6)
    for (int v = 0; v < NVEC; v++) begin
      logic [VW-1:0] e;
      e = VECS[v];
      restart(e[VW-1 -: 64], e[VW-65 -: 64], e[10:3]);
      cyc(4*NREG + 10);
      chk("R1/R2/R6 table cause", int'(fault_cause), int'(e[2:0]));
      chk("R9 table request", int'(disable_req), int'(e[2:0] != 3'd0));
    end

    // R2: mirror flip shows two edges later
    restart(64'hA5A5A5A55A5A5A5A, 64'h0, 8'h00);
    cyc(4*NREG);
    shadow_bank[12] = ~shadow_bank[12];
    cyc(1);
    chk("R2 not before second edge", int'(disable_req), 0);
    cyc(1);
    chk("R2 mirror cause", int'(fault_cause), 1);

    // R1: same new byte in both banks, old reference kept -> CRC only
    restart(64'h1122334455667788, 64'h0, 8'h00);
    cyc(4*NREG);
    chk("R1 clean before change", int'(disable_req), 0);
    cfg_bank[23:16] = 8'h3C;
    shadow_bank[23:16] = 8'h3C;
    cyc(2*NREG + 4);
    chk("R1 crc cause", int'(fault_cause), 2);

    // R5: strap wiggles before init are ignored
    restart(64'h0, 64'h0, 8'h00);
    cyc(5);
    strap_test = 2'b10;
    strap_gain = 1'b0;
    cyc(DG + 8);
    strap_test = 2'b01;
    strap_gain = 1'b1;
    arm();
    cyc(DG + 8);
    chk("R5 no fault before capture", int'(disable_req), 0);

    // R3: test strap change after capture
    strap_test[1] = 1'b1;
    cyc(4);
    chk("R3 test strap cause", int'(fault_cause), 3);

    // R7: later mirror fault does not overwrite
    shadow_bank[0] = ~shadow_bank[0];
    cyc(6);
    chk("R7 cause held", int'(fault_cause), 3);
    chk("R7 request held", int'(disable_req), 1);

    // R8: asynchronous clear mid-fault
    #(CLK_PERIOD/4);
    rst_n = 1'b0;
    #1;
    chk("R8 async clear", int'(disable_req), 0);
    chk("R8 async clear cause", int'(fault_cause), 0);

    // R4: short gain excursion filtered, long one latched
    restart(64'h0, 64'h0, 8'h00);
    arm();
    strap_gain = 1'b0;
    cyc(6);
    strap_gain = 1'b1;
    cyc(DG + 10);
    chk("R4 short glitch ignored", int'(disable_req), 0);
    strap_gain = 1'b0;
    cyc(DG);
    chk("R4 not before de-glitch", int'(disable_req), 0);
    cyc(6);
    chk("R4 gain cause", int'(fault_cause), 4);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule